// File: doc/BRIEF.md
# Dual-Half Stack Pointer Unit

This unit computes the next value of a 36-bit stack pointer word together with the memory address a stack access should use and an overflow trap flag. The pointer word holds two independent 18-bit fields. The upper field is a signed control count. The lower field is the address of the current top of the stack. A stack of N words placed at address A starts out as count -N and address A-1.

Each cycle the unit receives an operation code, the current pointer and an 18-bit signed adjust amount. It returns the updated pointer, the access address and the trap flag. Push, pop and adjust change both fields together, but each field wraps on its own, modulo 2^18, and no carry or borrow crosses from the address field into the count field. Overflow is detected only from the sign of the count, never from comparing the address against a limit. The memory transfer itself is done by the surrounding logic. With the default setting the results are registered, so they appear one clock after the inputs.

Top module: `stack_ptr_unit`

## Requirements
- R1: While `rst_n` is low, the registered outputs are cleared at the clock edge: `ptr_o` is 0, `addr_o` is 0 and `trap_o` is 0.
- R2: Push (`op_i` = 2'b01) adds 1 to the count field (bits 35:18) and adds 1 to the address field (bits 17:0). An address of 18'h3FFFF wraps to 0 and leaves the count field changed only by its own +1.
- R3: For push, `addr_o` equals the address field after the increment.
- R4: Push raises `trap_o` when the incremented count is zero or positive (bit 35 of the new pointer clear). The pointer is still updated.
- R5: Pop (`op_i` = 2'b10) subtracts 1 from each field separately. An address of 0 wraps to 18'h3FFFF without borrowing from the count. `addr_o` is the address field before the decrement.
- R6: Pop raises `trap_o` when the decremented count is negative (bit 35 of the new pointer set). The pointer is still updated.
- R7: Adjust (`op_i` = 2'b11) adds `amount_i`, read as two's complement with bit 17 as its sign, to each field independently modulo 2^18. `addr_o` is the new address field. An amount of zero leaves the pointer unchanged.
- R8: Adjust raises `trap_o` only in two cases: a negative amount moves the count from zero-or-positive to negative, or a positive amount moves it from negative to zero-or-positive. A positive amount that wraps a positive count to negative does not trap.
- R9: Idle (`op_i` = 2'b00) returns the pointer unchanged, `addr_o` equal to its address field and `trap_o` low. `amount_i` is ignored.
- R10: With `REG_OUT` = 1, every output reflects the inputs sampled at the previous rising clock edge, and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 2 | Operation: 00 idle, 01 push, 10 pop, 11 adjust |
| ptr_i | input | 36 | Current pointer: count in 35:18, address in 17:0 |
| amount_i | input | 18 | Signed adjust amount |
| ptr_o | output | 36 | Updated pointer |
| addr_o | output | 18 | Address for the stack memory access |
| trap_o | output | 1 | Stack overflow or trap indication |

## Verification
The bench walks a freshly set-up four-word stack through pushes until the count reaches zero. A design that tested for a strictly positive count would miss the trap on that final push. It pushes from address 18'h3FFFF and pops from address 0 to catch a carry or borrow leaking into the count, which would shift the count by one. It also checks that pop reports the address from before the decrement; a design using the new address would be off by one. Adjust is driven across both sign crossings, with a zero amount, and with a positive amount that wraps a positive count to negative. A design that looked only at the new sign, or that trapped on any sign change, would flag that wrapping case wrongly.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int HALF_W  = 18,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            op_i,
  input  logic [2*HALF_W-1:0]   ptr_i,
  input  logic [HALF_W-1:0]     amount_i,
  output logic [2*HALF_W-1:0]   ptr_o,
  output logic [HALF_W-1:0]     addr_o,
  output logic                  trap_o
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int MSB    = HALF_W - 1;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_ADJ  = 2'b11
  } stk_op_e;

  stk_op_e           op;
  logic [HALF_W-1:0] cnt, loc, cnt_n, loc_n, addr_n;
  logic              trap_n, amt_neg, amt_pos;

  assign op      = stk_op_e'(op_i);
  assign cnt     = ptr_i[WORD_W-1:HALF_W];
  assign loc     = ptr_i[HALF_W-1:0];
  assign amt_neg = amount_i[MSB];
  assign amt_pos = !amount_i[MSB] && (|amount_i);

  always_comb begin
    cnt_n  = cnt;
    loc_n  = loc;
    addr_n = loc;
    trap_n = 1'b0;
    case (op)
      OP_PUSH: begin
        cnt_n  = cnt + 1'b1;
        loc_n  = loc + 1'b1;
        addr_n = loc_n;
        trap_n = !cnt_n[MSB];
      end
      OP_POP: begin
        cnt_n  = cnt - 1'b1;
        loc_n  = loc - 1'b1;
        addr_n = loc;
        trap_n = cnt_n[MSB];
      end
      OP_ADJ: begin
        cnt_n  = cnt + amount_i;
        loc_n  = loc + amount_i;
        addr_n = loc_n;
        trap_n = (amt_neg && !cnt[MSB] && cnt_n[MSB]) ||
                 (amt_pos && cnt[MSB] && !cnt_n[MSB]);
      end
      default: ;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      logic armed_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ptr_o   <= '0;
          addr_o  <= '0;
          trap_o  <= 1'b0;
          armed_q <= 1'b0;
        end else begin
          ptr_o   <= {cnt_n, loc_n};
          addr_o  <= addr_n;
          trap_o  <= trap_n;
          armed_q <= 1'b1;
        end
      end

      assert_push_nocarry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i == OP_PUSH && ptr_i[HALF_W-1:0] == '1) |->
          ptr_o[HALF_W-1:0] == '0 &&
          ptr_o[WORD_W-1:HALF_W] == HALF_W'($past(ptr_i[WORD_W-1:HALF_W]) + 1'b1));

      assert_push_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i == OP_PUSH) |-> addr_o == ptr_o[HALF_W-1:0]);

      assert_push_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i == OP_PUSH && ptr_i[WORD_W-1:HALF_W] == '1) |-> trap_o);

      assert_pop_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i == OP_POP) |-> addr_o == $past(ptr_i[HALF_W-1:0]));

      assert_pop_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i == OP_POP && ptr_i[WORD_W-1:HALF_W] == '0) |-> trap_o);

      assert_adj_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i == OP_ADJ && amount_i == '0) |->
          ptr_o == $past(ptr_i) && !trap_o);

      assert_adj_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i == OP_ADJ && !ptr_i[WORD_W-1] && !amount_i[MSB]) |-> !trap_o);

      assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i == OP_IDLE) |->
          ptr_o == $past(ptr_i) && addr_o == $past(ptr_i[HALF_W-1:0]) && !trap_o);
    end else begin : g_comb
      assign ptr_o  = {cnt_n, loc_n};
      assign addr_o = addr_n;
      assign trap_o = trap_n;
    end
  endgenerate
endmodule

// File: tb/stack_ptr_unit_test.sv
module stack_ptr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [35:0] ptr_i = '0;
  logic [17:0] amount_i = '0;
  logic [35:0] ptr_o;
  logic [17:0] addr_o;
  logic        trap_o;

  int checks = 0;
  int fails  = 0;

  localparam logic [1:0] IDLE = 2'b00, PUSH = 2'b01, POP = 2'b10, ADJ = 2'b11;

  always #10 clk = ~clk;

  stack_ptr_unit uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .ptr_i(ptr_i),
    .amount_i(amount_i), .ptr_o(ptr_o), .addr_o(addr_o), .trap_o(trap_o)
  );

  task automatic chk(string req, logic [35:0] got, logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(logic [1:0] op, logic [35:0] p, logic [17:0] amt,
                      logic [35:0] ep, logic [17:0] ea, logic et, string req);
    @(negedge clk);
    op_i = op; ptr_i = p; amount_i = amt;
    @(negedge clk);
    chk({req, " ptr"},  ptr_o, ep);
    chk({req, " addr"}, 36'(addr_o), 36'(ea));
    chk({req, " trap"}, 36'(trap_o), 36'(et));
  endtask

  task automatic t_reset();
    @(negedge clk);
    op_i = PUSH; ptr_i = {18'h3FFFF, 18'h00010};
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ptr",  ptr_o, '0);
    chk("R1 addr", 36'(addr_o), '0);
    chk("R1 trap", 36'(trap_o), '0);
    rst_n = 1'b1;
  endtask

  task automatic t_push_stack();
    logic [35:0] p = {18'h3FFFC, 18'h000FF};
    for (int i = 1; i <= 4; i++) begin
      logic [35:0] e = {18'(18'h3FFFC + i), 18'(18'h000FF + i)};
      step(PUSH, p, '0, e, e[17:0], (i == 4), "R4 push stack");
      p = ptr_o;
    end
    step(PUSH, {18'h1FFFF, 18'h00020}, '0, {18'h20000, 18'h00021}, 18'h00021, 1'b0, "R3 push to negative");
  endtask

  task automatic t_push_wrap();
    step(PUSH, {18'h00005, 18'h3FFFF}, '0, {18'h00006, 18'h00000}, 18'h00000, 1'b1, "R2 push wrap");
  endtask

  task automatic t_pop();
    step(POP, {18'h00003, 18'h00010}, '0, {18'h00002, 18'h0000F}, 18'h00010, 1'b0, "R5 pop plain");
    step(POP, {18'h00007, 18'h00000}, '0, {18'h00006, 18'h3FFFF}, 18'h00000, 1'b0, "R5 pop borrow");
    step(POP, {18'h00000, 18'h00005}, '0, {18'h3FFFF, 18'h00004}, 18'h00005, 1'b1, "R6 pop to negative");
    step(POP, {18'h3FFFD, 18'h00101}, '0, {18'h3FFFC, 18'h00100}, 18'h00101, 1'b1, "R6 pop negative");
  endtask

  task automatic t_adjust();
    step(ADJ, {18'h3FFFC, 18'h00100}, 18'h00003, {18'h3FFFF, 18'h00103}, 18'h00103, 1'b0, "R7 adj up");
    step(ADJ, {18'h3FFFE, 18'h3FFFE}, 18'h00003, {18'h00001, 18'h00001}, 18'h00001, 1'b1, "R7 adj wrap");
    step(ADJ, {18'h3FFFC, 18'h00123}, 18'h00000, {18'h3FFFC, 18'h00123}, 18'h00123, 1'b0, "R7 adj zero");
    step(ADJ, {18'h3FFFC, 18'h00100}, 18'h00005, {18'h00001, 18'h00105}, 18'h00105, 1'b1, "R8 neg to pos");
    step(ADJ, {18'h00001, 18'h00010}, 18'h3FFFE, {18'h3FFFF, 18'h0000E}, 18'h0000E, 1'b1, "R8 pos to neg");
    step(ADJ, {18'h3FFF0, 18'h00010}, 18'h3FFFE, {18'h3FFEE, 18'h0000E}, 18'h0000E, 1'b0, "R8 stays neg");
    step(ADJ, {18'h1FFFF, 18'h00010}, 18'h00001, {18'h20000, 18'h00011}, 18'h00011, 1'b0, "R8 pos wraps");
  endtask

  task automatic t_idle();
    step(IDLE, {18'h12345, 18'h23456}, 18'h3ABCD, {18'h12345, 18'h23456}, 18'h23456, 1'b0, "R9 idle");
  endtask

  task automatic t_latency();
    step(IDLE, {18'h00111, 18'h00222}, '0, {18'h00111, 18'h00222}, 18'h00222, 1'b0, "R10 prime");
    @(negedge clk);
    op_i = PUSH; ptr_i = {18'h00AAA, 18'h00BBB};
    #5;
    chk("R10 before edge", ptr_o, {18'h00111, 18'h00222});
    @(negedge clk);
    chk("R10 after edge", ptr_o, {18'h00AAB, 18'h00BBC});
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_push_stack();
    t_push_wrap();
    t_pop();
    t_adjust();
    t_idle();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule